// File: doc/BRIEF.md
# Selectable Event Statistics Counter Bank

This block keeps error statistics for a serial link's physical and link layers. Detection logic elsewhere raises one-cycle pulses, one wire per event type. For the two groups that are tracked per lane, each event has one wire per lane. Each implemented event has its own saturating counter, and lane-tracked events have one counter per lane. Nothing counts until software turns the event on.

Software works through two registers on a simple synchronous register port. It writes a control word that picks a group, an event within that group and a lane. The same write can carry an on/off command, and that command applies to the event named in that same word. Reading the control word returns the current selection and a status bit. The status bit shows whether the selected event is really counting, so an event that is not implemented stays visibly off. Reading the data register returns the count for the current selection.

The event pulses have no back-pressure. Every pulse is taken in the cycle it arrives, so the bank never stalls its sources. The register port has no handshake beyond the read-valid flag. A read always completes in exactly one cycle.

Top module: `evc_bank`

## Requirements
- R1: After reset every counter is zero and every event is disabled. A control read returns 0, a data read returns 0, and `reg_rvalid_o` is low until the first read strobe.
- R2: The control register is at offset 0x8. Its fields are group in bits 27:24, event in bits 23:16 and lane in bits 11:8. These three fields read back as written. Bit 7 is the status bit. The command field in bits 4:2 and every other bit read as 0.
- R3: A control write with command 3 enables the event named in that write, and command 1 disables it. Any other command value, including 0, leaves every enable state unchanged. Writes to the data offset never change an enable.
- R4: Status reads 1 only when the currently selected group/event is implemented and enabled. The implemented events are: group 0 events 0–10, group 1 events 5–10, 12 and 13, group 2 events 0–7, group 3 events 0–5, and group 4 events 0–1. A command 3 aimed at any other pair, such as group 1 event 11, group 0 event 11 or group 5, leaves status at 0.
- R5: While an event is enabled, each cycle with its pulse high adds one to its counter. While it is disabled, pulses are ignored. Disabling an event freezes its count without clearing it.
- R6: Groups 0 and 4 have one counter per lane (four lanes by default). A data read returns the counter of the selected lane. A lane value of 4 or more reads 0. Pulse input bit e×4+l of `g0_ev_i` or `g4_ev_i` is event e on lane l.
- R7: For groups 1, 2 and 3 the lane field has no effect on which counter a data read returns.
- R8: A counter stops at all-ones and does not wrap to zero.
- R9: `reg_rvalid_o` is high exactly in the cycle after a read strobe. `reg_rdata_o` then holds the value from the strobe cycle. The data register is at offset 0xC. Reads of any other offset return 0, and writes to 0xC change nothing.
- R10: One enable covers all lanes of a lane-tracked event. Pulses on several lanes in the same cycle each advance their own lane's counter.
- R11: Bits of `g1_ev_i` map to group 1 events in this order: bits 0–5 are events 5–10, bit 6 is event 12 and bit 7 is event 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W (8) | Register offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| g0_ev_i | input | 11×LANES (44) | Group 0 pulses, bit e×LANES+l |
| g1_ev_i | input | 8 | Group 1 pulses, order per R11 |
| g2_ev_i | input | 8 | Group 2 pulses, bit = event |
| g3_ev_i | input | 6 | Group 3 pulses, bit = event |
| g4_ev_i | input | 2×LANES (8) | Group 4 pulses, bit e×LANES+l |

## Verification
Directed runs first send a long burst on one event. This separates correct counting from wrap-around in a narrow-counter copy of the block. A later burst sent after the disable command checks that the count freezes. Lane-tracked events get two patterns: pulses on all lanes at once, then pulses on one lane only. Together these show that the enable is shared across lanes while the counters are separate. Random pulses on every input, mixed with random commands (including unimplemented groups and events and the neutral codes), are then checked counter by counter against a bench model. This exposes any wrong index mapping between pulse bits, enables and readback slots.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int GRP_CNT  = 5;
  localparam int EV_TOTAL = 35;

  localparam int GRP_LSB  = 24;
  localparam int EVT_LSB  = 16;
  localparam int LANE_LSB = 8;
  localparam int STAT_BIT = 7;
  localparam int CMD_LSB  = 2;

  localparam logic [2:0] CMD_ON  = 3'd3;
  localparam logic [2:0] CMD_OFF = 3'd1;

  typedef struct packed {
    logic [3:0] grp;
    logic [7:0] evt;
    logic [3:0] lane;
  } evc_sel_t;

  // number of implemented events (slots) per group
  function automatic int grp_slots(input int g);
    case (g)
      0:       return 11;
      1:       return 8;
      2:       return 8;
      3:       return 6;
      4:       return 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit grp_laned(input int g);
    return (g == 0) || (g == 4);
  endfunction

  // slot within group -> architectural event number
  function automatic int slot_to_ev(input int g, input int k);
    if (g == 1) return (k < 6) ? k + 5 : k + 6;
    return k;
  endfunction

  function automatic int ev_to_slot(input int g, input int e);
    if (g == 1) return (e < 11) ? e - 5 : e - 6;
    return e;
  endfunction

  function automatic bit ev_valid(input int g, input int e);
    if (g == 1) return (e >= 5) && (e <= 13) && (e != 11);
    return (g >= 0) && (g < GRP_CNT) && (e >= 0) && (e < grp_slots(g));
  endfunction

  function automatic int ev_base(input int g);
    int s = 0;
    for (int i = 0; i < GRP_CNT; i++)
      if (i < g) s += grp_slots(i);
    return s;
  endfunction

  function automatic int cnt_base(input int g, input int lanes);
    int s = 0;
    for (int i = 0; i < GRP_CNT; i++)
      if (i < g) s += grp_slots(i) * (grp_laned(i) ? lanes : 1);
    return s;
  endfunction

  function automatic int cnt_total(input int lanes);
    return cnt_base(GRP_CNT, lanes);
  endfunction
endpackage

// File: rtl/evc_sat_counter.sv
module evc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (inc && !(&cnt_q))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evc_ctrl_regs.sv
module evc_ctrl_regs
  import evc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output evc_sel_t            sel_o,
  output logic [EV_TOTAL-1:0] en_vec_o
);
  logic       wr_ctrl;
  logic [3:0] w_grp;
  logic [7:0] w_evt;
  logic [3:0] w_lane;
  logic [2:0] w_cmd;
  logic       unused_wdata_bits;
  evc_sel_t   sel_q;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(CTRL_OFS));
  assign w_grp   = wdata[GRP_LSB +: 4];
  assign w_evt   = wdata[EVT_LSB +: 8];
  assign w_lane  = wdata[LANE_LSB +: 4];
  assign w_cmd   = wdata[CMD_LSB +: 3];
  assign unused_wdata_bits = ^{wdata[31:28], wdata[15:12], wdata[7:5], wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= '0;
    else if (wr_ctrl) sel_q <= '{grp: w_grp, evt: w_evt, lane: w_lane};
  end

  assign sel_o = sel_q;

  // one enable flop per implemented event; command applies to the word's own selection
  for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
    for (genvar k = 0; k < grp_slots(g); k++) begin : g_ev
      localparam int EV_NUM = slot_to_ev(g, k);
      localparam int EV_IDX = ev_base(g) + k;
      logic hit;
      logic en_r;

      assign hit = wr_ctrl && (w_grp == 4'(g)) && (w_evt == 8'(EV_NUM));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_r <= 1'b0;
        else if (hit) begin
          if (w_cmd == CMD_ON)       en_r <= 1'b1;
          else if (w_cmd == CMD_OFF) en_r <= 1'b0;
        end
      end

      assign en_vec_o[EV_IDX] = en_r;
    end
  end
endmodule

// File: rtl/evc_counter_array.sv
module evc_counter_array
  import evc_pkg::*;
#(
  parameter  int LANES = 4,
  parameter  int CNT_W = 32,
  localparam int NSLOT = cnt_total(LANES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSLOT-1:0]            ev_flat,
  input  logic [EV_TOTAL-1:0]         en_vec,
  output logic [NSLOT-1:0][CNT_W-1:0] cnt_flat
);
  for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
    localparam int NL = grp_laned(g) ? LANES : 1;
    for (genvar k = 0; k < grp_slots(g); k++) begin : g_ev
      for (genvar l = 0; l < NL; l++) begin : g_lane
        localparam int SLOT = cnt_base(g, LANES) + k * NL + l;
        localparam int EIDX = ev_base(g) + k;
        evc_sat_counter #(.W(CNT_W)) u_cnt (
          .clk   (clk),
          .rst_n (rst_n),
          .inc   (ev_flat[SLOT] & en_vec[EIDX]),
          .cnt_o (cnt_flat[SLOT])
        );
      end
    end
  end
endmodule

// File: rtl/evc_readback.sv
module evc_readback
  import evc_pkg::*;
#(
  parameter  int ADDR_W   = 8,
  parameter  int LANES    = 4,
  parameter  int CNT_W    = 32,
  parameter  int CTRL_OFS = 8,
  parameter  int DATA_OFS = 12,
  localparam int NSLOT    = cnt_total(LANES),
  localparam int EIW      = $clog2(EV_TOTAL),
  localparam int CIW      = $clog2(NSLOT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  evc_sel_t                    sel,
  input  logic [EV_TOTAL-1:0]         en_vec,
  input  logic [NSLOT-1:0][CNT_W-1:0] cnt_flat,
  output logic [31:0]                 rdata_o,
  output logic                        rvalid_o
);
  int          gi, ei, li, es, eidx_i, cidx_i;
  logic        sel_ok, laned, lane_ok, status;
  logic [31:0] ctrl_word, cnt_word;

  always_comb begin
    gi      = int'(sel.grp);
    ei      = int'(sel.evt);
    li      = int'(sel.lane);
    sel_ok  = ev_valid(gi, ei);
    laned   = grp_laned(gi);
    lane_ok = !laned || (li < LANES);
    es      = sel_ok ? ev_to_slot(gi, ei) : 0;
    eidx_i  = sel_ok ? ev_base(gi) + es : 0;
    cidx_i  = sel_ok ? cnt_base(gi, LANES) + (laned ? es * LANES + (lane_ok ? li : 0) : es) : 0;
    status  = sel_ok && en_vec[EIW'(eidx_i)];

    ctrl_word                  = '0;
    ctrl_word[GRP_LSB +: 4]    = sel.grp;
    ctrl_word[EVT_LSB +: 8]    = sel.evt;
    ctrl_word[LANE_LSB +: 4]   = sel.lane;
    ctrl_word[STAT_BIT]        = status;

    cnt_word = (sel_ok && lane_ok) ? 32'(cnt_flat[CIW'(cidx_i)]) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_en;
      if (rd_en) begin
        if (addr == ADDR_W'(CTRL_OFS))      rdata_o <= ctrl_word;
        else if (addr == ADDR_W'(DATA_OFS)) rdata_o <= cnt_word;
        else                                rdata_o <= '0;
      end
    end
  end
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter  int ADDR_W   = 8,
  parameter  int LANES    = 4,
  parameter  int CNT_W    = 32,
  parameter  int CTRL_OFS = 8,
  parameter  int DATA_OFS = 12,
  localparam int G0_W     = grp_slots(0) * LANES,
  localparam int G1_W     = grp_slots(1),
  localparam int G2_W     = grp_slots(2),
  localparam int G3_W     = grp_slots(3),
  localparam int G4_W     = grp_slots(4) * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              reg_rvalid_o,
  input  logic [G0_W-1:0]   g0_ev_i,
  input  logic [G1_W-1:0]   g1_ev_i,
  input  logic [G2_W-1:0]   g2_ev_i,
  input  logic [G3_W-1:0]   g3_ev_i,
  input  logic [G4_W-1:0]   g4_ev_i
);
  localparam int NSLOT = cnt_total(LANES);

  evc_sel_t                    sel;
  logic [EV_TOTAL-1:0]         en_vec;
  logic [NSLOT-1:0]            ev_flat;
  logic [NSLOT-1:0][CNT_W-1:0] cnt_flat;

  assign ev_flat = {g4_ev_i, g3_ev_i, g2_ev_i, g1_ev_i, g0_ev_i};

  evc_ctrl_regs #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_i),
    .addr     (reg_addr_i),
    .wdata    (reg_wdata_i),
    .sel_o    (sel),
    .en_vec_o (en_vec)
  );

  evc_counter_array #(.LANES(LANES), .CNT_W(CNT_W)) u_cnts (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_flat  (ev_flat),
    .en_vec   (en_vec),
    .cnt_flat (cnt_flat)
  );

  evc_readback #(
    .ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W),
    .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
  ) u_rdbk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (reg_rd_i),
    .addr     (reg_addr_i),
    .sel      (sel),
    .en_vec   (en_vec),
    .cnt_flat (cnt_flat),
    .rdata_o  (reg_rdata_o),
    .rvalid_o (reg_rvalid_o)
  );
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk
  import evc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 8,
  parameter int CNT_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [2:0]          cmd,
  input logic [31:0]         rdata,
  input logic                rvalid,
  input logic [EV_TOTAL-1:0] en_vec,
  input logic [CNT_W-1:0]    cnt0
);
  logic unused_rdata_mid;
  assign unused_rdata_mid = ^{rdata[23:16], rdata[11:8]};

  a_r9_rvalid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  a_r9_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

  a_r2_ctrl_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(CTRL_OFS)) |=>
      (rdata[31:28] == 4'h0 && rdata[15:12] == 4'h0 && rdata[6:0] == 7'h0));

  a_r4_bad_group_never_on: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(CTRL_OFS)) |=> (rdata[27:24] <= 4'd4 || !rdata[7]));

  a_r3_neutral_write_keeps_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(CTRL_OFS) && (cmd == CMD_ON || cmd == CMD_OFF))
      |=> $stable(en_vec));

  a_r5_disabled_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en_vec[0] |=> $stable(cnt0));

  a_r8_saturated_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt0) |=> (&cnt0));
endmodule

bind evc_bank evc_bank_chk #(
  .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .CNT_W(CNT_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (reg_wr_i),
  .rd_en  (reg_rd_i),
  .addr   (reg_addr_i),
  .cmd    (reg_wdata_i[4:2]),
  .rdata  (reg_rdata_o),
  .rvalid (reg_rvalid_o),
  .en_vec (en_vec),
  .cnt0   (cnt_flat[0])
);

// File: tb/evc_bank_tb.sv
`timescale 1ns/1ps
module evc_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr, rd;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [43:0] g0;
  logic [7:0]  g1, g2, g4;
  logic [5:0]  g3;
  logic [31:0] rdata, rdata_s;
  logic        rvld, rvld_s;

  always #4 clk = ~clk;

  evc_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_rvalid_o(rvld),
    .g0_ev_i(g0), .g1_ev_i(g1), .g2_ev_i(g2), .g3_ev_i(g3), .g4_ev_i(g4)
  );

  evc_bank #(.CNT_W(6)) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_s), .reg_rvalid_o(rvld_s),
    .g0_ev_i(g0), .g1_ev_i(g1), .g2_ev_i(g2), .g3_ev_i(g3), .g4_ev_i(g4)
  );

  int checks = 0;
  int errors = 0;
  bit en_m [5][14];
  longint unsigned cnt_m [5][14][4];

  function automatic bit m_impl(int g, int e);
    case (g)
      0: return e <= 10;
      1: return e >= 5 && e <= 13 && e != 11;
      2: return e <= 7;
      3: return e <= 5;
      4: return e <= 1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int m_lanes(int g);
    return (g == 0 || g == 4) ? 4 : 1;
  endfunction

  function automatic bit m_pulse(int g, int e, int l);
    case (g)
      0: return g0[e*4+l];
      1: return g1[(e < 11) ? e - 5 : e - 6];
      2: return g2[e];
      3: return g3[e];
      default: return g4[e*4+l];
    endcase
  endfunction

  function automatic logic [31:0] ctl_word(int g, int e, int l, int cmd);
    return (32'(g) << 24) | (32'(e) << 16) | (32'(l) << 8) | (32'(cmd) << 2);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(bit w, bit r, logic [7:0] a, logic [31:0] d,
                       logic [43:0] v0, logic [7:0] v1, logic [7:0] v2,
                       logic [5:0] v3, logic [7:0] v4);
    int wg, we, wc;
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
    g0 = v0; g1 = v1; g2 = v2; g3 = v3; g4 = v4;
    for (int g = 0; g < 5; g++)
      for (int e = 0; e < 14; e++)
        for (int l = 0; l < m_lanes(g); l++)
          if (m_impl(g, e) && en_m[g][e] && m_pulse(g, e, l) && cnt_m[g][e][l] < 64'hFFFF_FFFF)
            cnt_m[g][e][l]++;
    if (w && a == 8'h08) begin
      wg = int'(d[27:24]); we = int'(d[23:16]); wc = int'(d[4:2]);
      if (m_impl(wg, we) && we < 14) begin
        if (wc == 3) en_m[wg][we] = 1'b1;
        else if (wc == 1) en_m[wg][we] = 1'b0;
      end
    end
  endtask

  task automatic idle();
    drive(0, 0, 8'h0, 32'h0, '0, '0, '0, '0, '0);
  endtask

  task automatic wctl(int g, int e, int l, int cmd);
    drive(1, 0, 8'h08, ctl_word(g, e, l, cmd), '0, '0, '0, '0, '0);
  endtask

  task automatic rdreg(logic [7:0] a, output logic [31:0] got, output logic [31:0] got_s);
    drive(0, 1, a, 32'h0, '0, '0, '0, '0, '0);
    idle();
    check("R9 rvalid after strobe", {31'h0, rvld}, 32'h1);
    got = rdata;
    got_s = rdata_s;
  endtask

  task automatic pulses(int n, logic [43:0] v0, logic [7:0] v1, logic [7:0] v2,
                        logic [5:0] v3, logic [7:0] v4);
    repeat (n) drive(0, 0, 8'h0, 32'h0, v0, v1, v2, v3, v4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, vs;
    rst_n = 1'b0; wr = 0; rd = 0; addr = 0; wdata = 0;
    g0 = 0; g1 = 0; g2 = 0; g3 = 0; g4 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    void'($urandom(32'h5EED_0123));

    // R1 reset state
    idle();
    check("R1 rvalid low before any read", {31'h0, rvld}, 32'h0);
    rdreg(8'h08, v, vs); check("R1 control after reset", v, 32'h0);
    rdreg(8'h0C, v, vs); check("R1 data after reset", v, 32'h0);
    idle();
    check("R9 rvalid drops without strobe", {31'h0, rvld}, 32'h0);

    // R2 field readback, command field reads zero
    wctl(2, 5, 3, 0);
    rdreg(8'h08, v, vs); check("R2 selection fields", v, 32'h0205_0300);

    // R4 unimplemented selections never report enabled
    wctl(1, 11, 0, 3); rdreg(8'h08, v, vs); check("R4 group1 event11 status", v, 32'h010B_0000);
    wctl(0, 11, 0, 3); rdreg(8'h08, v, vs); check("R4 group0 event11 status", v, 32'h000B_0000);
    wctl(5, 0, 0, 3);  rdreg(8'h08, v, vs); check("R4 group5 status", v, 32'h0500_0000);

    // R3 enable, neutral codes, selection-only writes
    wctl(2, 0, 0, 3); rdreg(8'h08, v, vs); check("R3 enable via code 3", v, 32'h0200_0080);
    wctl(3, 1, 0, 0); wctl(2, 0, 0, 0);
    rdreg(8'h08, v, vs); check("R3 selection-only write keeps enable", v, 32'h0200_0080);
    wctl(2, 0, 0, 2); rdreg(8'h08, v, vs); check("R3 code 2 no effect", v, 32'h0200_0080);
    wctl(2, 0, 0, 7); rdreg(8'h08, v, vs); check("R3 code 7 no effect", v, 32'h0200_0080);

    // R8 saturation on the narrow copy, plain count on the 32-bit one
    pulses(70, '0, '0, 8'h01, '0, '0);
    rdreg(8'h0C, v, vs);
    check("R5 count of 70 pulses", v, 32'd70);
    check("R8 narrow counter saturates", vs, 32'd63);

    // R5 disable freezes
    wctl(2, 0, 0, 1);
    pulses(5, '0, '0, 8'h01, '0, '0);
    rdreg(8'h0C, v, vs); check("R5 count frozen after disable", v, 32'd70);
    rdreg(8'h08, v, vs); check("R3 disable via code 1", v, 32'h0200_0000);

    // R9 data writes ignored, unmapped offset reads zero
    drive(1, 0, 8'h0C, 32'hFFFF_FFFF, '0, '0, '0, '0, '0);
    rdreg(8'h0C, v, vs); check("R9 data write ignored", v, 32'd70);
    rdreg(8'h08, v, vs); check("R9 selection kept after data write", v, 32'h0200_0000);
    rdreg(8'h04, v, vs); check("R9 unmapped offset", v, 32'h0);

    // R10 / R6 lanes: group0 event3 occupies bits 12..15
    wctl(0, 3, 0, 3);
    pulses(4, 44'h0_000F_000, '0, '0, '0, '0);
    pulses(5, 44'h0_0004_000, '0, '0, '0, '0);
    for (int l = 0; l < 4; l++) begin
      wctl(0, 3, l, 0);
      rdreg(8'h0C, v, vs);
      check("R10 R6 per-lane count", v, (l == 2) ? 32'd9 : 32'd4);
    end
    wctl(0, 3, 5, 0); rdreg(8'h0C, v, vs); check("R6 lane out of range", v, 32'h0);

    // R7 lane ignored for group 3; R11 group1 bit order
    wctl(3, 2, 0, 3);
    pulses(6, '0, '0, '0, 6'h04, '0);
    wctl(3, 2, 0, 0); rdreg(8'h0C, v, vs); check("R7 group3 lane0", v, 32'd6);
    wctl(3, 2, 9, 0); rdreg(8'h0C, v, vs); check("R7 group3 lane9", v, 32'd6);
    wctl(1, 12, 0, 3);
    pulses(3, '0, 8'h40, '0, '0, '0);
    rdreg(8'h0C, v, vs); check("R11 group1 event12 on bit6", v, 32'd3);

    // random phase
    for (int c = 0; c < 400; c++) begin
      logic [43:0] r0;
      r0 = {$urandom(), $urandom()};
      if ($urandom() % 6 == 0) begin
        int cmd;
        case ($urandom() % 4)
          0: cmd = 3;
          1: cmd = 1;
          2: cmd = 0;
          default: cmd = int'($urandom() % 8);
        endcase
        drive(1, 0, 8'h08, ctl_word(int'($urandom() % 6), int'($urandom() % 15),
              int'($urandom() % 8), cmd),
              r0, 8'($urandom()), 8'($urandom()), 6'($urandom()), 8'($urandom()));
      end else begin
        drive(0, 0, 8'h0, 32'h0, r0, 8'($urandom()), 8'($urandom()),
              6'($urandom()), 8'($urandom()));
      end
    end

    // sweep every counter and status against the model (R5, R4, R6)
    for (int g = 0; g < 5; g++)
      for (int e = 0; e < 14; e++)
        if (m_impl(g, e))
          for (int l = 0; l < m_lanes(g); l++) begin
            wctl(g, e, l, 0);
            rdreg(8'h0C, v, vs);
            check("R5 random counter vs model", v, 32'(cnt_m[g][e][l]));
            if (l == 0) begin
              rdreg(8'h08, v, vs);
              check("R4 random status vs model", v, ctl_word(g, e, 0, 0) | (32'(en_m[g][e]) << 7));
            end
          end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule